// File: doc/BRIEF.md
# Prefix-Match Route and Firewall Table

This block stands where packets enter a sub-network. Each arriving packet carries a virtual destination address. The block compares that address against a small table of ternary entries. Each entry holds a base value and a prefix length: the leading bits are compared and the trailing bits are don't-care. One entry can therefore stand for a whole aligned block of pages.

When several entries match, the most specific one decides the outgoing port. That is the one with the longest prefix. An entry can name a final location for nearby pages, or it can point toward a further table for distant ones. Either way the packet leaves with its virtual address unchanged.

An entry can also be marked as guarding a protected region. A packet that matches such an entry and comes from outside the partition is flagged for dropping. A configuration write port rewrites single entries while traffic flows, so a page can be migrated by touching only the entries that cover it.

Top module: `lpf_firewall`

## Requirements
- R1: After synchronous reset every entry is invalid and `rsp_valid` is low, so the first lookup after reset misses.
- R2: An entry matches when it is valid and the top `len` bits of the lookup address equal the top `len` bits of its base. Length 0 matches every address, and a length above 16 is treated as 16.
- R3: When several entries match, the one with the greatest prefix length supplies `rsp_port`, `rsp_miss` is 0, and the protection of that entry alone applies.
- R4: Among matching entries of equal length, the one with the lowest index wins.
- R5: When no entry matches, the response shows `rsp_miss`=1, `rsp_port`=DEFAULT_PORT (0) and `rsp_drop`=0.
- R6: `rsp_drop` is 1 exactly when the winning entry is protected and `lk_outside` was 1 for that lookup. The port is still reported.
- R7: A lookup presented in cycle N is answered in cycle N+1: `rsp_valid` follows `lk_valid` by one cycle, and `rsp_addr` equals the looked-up address unchanged.
- R8: A configuration write in cycle N affects lookups from cycle N+1 onward. A lookup in the same cycle as the write sees the previous contents.
- R9: Rewriting or invalidating one entry changes the result only for addresses whose winning entry changes. Other routes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_idx | input | 4 | Entry index to write |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_prot | input | 1 | Protected-region bit of the written entry |
| cfg_len | input | 5 | Prefix length, 0..16 |
| cfg_base | input | 16 | Base value compared under the prefix |
| cfg_port | input | 3 | Next-hop port of the entry |
| lk_valid | input | 1 | A lookup is presented |
| lk_addr | input | 16 | Virtual destination address |
| lk_outside | input | 1 | Packet originates outside the partition |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 16 | Address passed through unchanged |
| rsp_port | output | 3 | Selected next-hop port |
| rsp_miss | output | 1 | No entry matched |
| rsp_drop | output | 1 | Packet must be discarded |

## Verification
The hardest situation to reach is a lookup in the very cycle an entry is rewritten, where the old and new contents must not blend. The bench raises the write enable and the lookup together on one falling edge and expects the old port. It then repeats the lookup and expects the new one. Nested and equal-length prefixes are staged so that one address is covered by a protected short entry and an unprotected longer one. This shows that only the winner's protection counts.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    localparam int ADDR_W = 16;
    localparam int N_ENT  = 16;
    localparam int PORT_W = 3;
    localparam int LEN_W  = $clog2(ADDR_W + 1);
    localparam int IDX_W  = $clog2(N_ENT);

    typedef struct packed {
        logic              valid;
        logic              prot;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
        logic [PORT_W-1:0] port;
    } route_ent_t;

    // Ones in the leading len bits, zeros in the don't-care tail.
    function automatic logic [ADDR_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        for (int b = 0; b < ADDR_W; b++)
            m[ADDR_W-1-b] = (int'(len) > b);
        return m;
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
        return (int'(len) > ADDR_W) ? LEN_W'(ADDR_W) : len;
    endfunction

endpackage

// File: rtl/lpf_table.sv
module lpf_table
    import lpf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  route_ent_t           wdata,
    output route_ent_t           ents [N_ENT]
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (we && idx == IDX_W'(g))
                ents[g] <= wdata;
        end
    end

endmodule

// File: rtl/lpf_match.sv
module lpf_match
    import lpf_pkg::*;
(
    input  route_ent_t           ents [N_ENT],
    input  logic [ADDR_W-1:0]    addr,
    output logic [N_ENT-1:0]     hit
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit[g] = ents[g].valid &&
                        (((addr ^ ents[g].base) & prefix_mask(ents[g].len)) == '0);
    end

endmodule

// File: rtl/lpf_select.sv
module lpf_select
    import lpf_pkg::*;
(
    input  route_ent_t           ents [N_ENT],
    input  logic [N_ENT-1:0]     hit,
    output logic                 found,
    output route_ent_t           win
);

    logic [IDX_W-1:0] best_idx;
    logic [LEN_W-1:0] best_len;

    // Strictly-greater compare keeps the lowest index on equal lengths.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_len = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i] && (!found || ents[i].len > best_len)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_len = ents[i].len;
            end
        end
        win = ents[best_idx];
    end

    // R3: a chosen winner must be one the comparators reported as matching
    always_comb begin
        if (found)
            a_r3_winner_matches: assert (hit[best_idx]);
    end

endmodule

// File: rtl/lpf_firewall.sv
module lpf_firewall
    import lpf_pkg::*;
#(
    parameter logic [PORT_W-1:0] DEFAULT_PORT = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_valid,
    input  logic                 cfg_prot,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic                 lk_valid,
    input  logic [ADDR_W-1:0]    lk_addr,
    input  logic                 lk_outside,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [PORT_W-1:0]    rsp_port,
    output logic                 rsp_miss,
    output logic                 rsp_drop
);

    route_ent_t        wr_ent;
    route_ent_t        ents [N_ENT];
    logic [N_ENT-1:0]  hit;
    logic              found;
    route_ent_t        win;

    always_comb begin
        wr_ent.valid = cfg_valid;
        wr_ent.prot  = cfg_prot;
        wr_ent.len   = clamp_len(cfg_len);
        wr_ent.base  = cfg_base;
        wr_ent.port  = cfg_port;
    end

    lpf_table u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (wr_ent),
        .ents  (ents)
    );

    lpf_match u_match (
        .ents (ents),
        .addr (lk_addr),
        .hit  (hit)
    );

    lpf_select u_select (
        .ents  (ents),
        .hit   (hit),
        .found (found),
        .win   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_port  <= '0;
            rsp_miss  <= 1'b0;
            rsp_drop  <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_addr <= lk_addr;
                rsp_miss <= !found;
                rsp_port <= found ? win.port : DEFAULT_PORT;
                rsp_drop <= found && win.prot && lk_outside;
            end
        end
    end

    // R1: reset leaves no response pending
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R7: one-cycle latency and address pass-through
    a_r7_resp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    a_r7_addr_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_addr == $past(lk_addr));

    // R5: a miss routes to the default port and never drops
    a_r5_miss_default: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_port == DEFAULT_PORT && !rsp_drop));

    // R6: a drop needs an outside source
    a_r6_drop_outside: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_drop) |-> $past(lk_outside));

endmodule

// File: tb/test_lpf_firewall.sv
module test_lpf_firewall;
    import lpf_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 cfg_we;
    logic [IDX_W-1:0]     cfg_idx;
    logic                 cfg_valid;
    logic                 cfg_prot;
    logic [LEN_W-1:0]     cfg_len;
    logic [ADDR_W-1:0]    cfg_base;
    logic [PORT_W-1:0]    cfg_port;
    logic                 lk_valid;
    logic [ADDR_W-1:0]    lk_addr;
    logic                 lk_outside;
    logic                 rsp_valid;
    logic [ADDR_W-1:0]    rsp_addr;
    logic [PORT_W-1:0]    rsp_port;
    logic                 rsp_miss;
    logic                 rsp_drop;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lpf_firewall i_lpf_firewall (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_prot(cfg_prot), .cfg_len(cfg_len), .cfg_base(cfg_base),
        .cfg_port(cfg_port),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_outside(lk_outside),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_port(rsp_port),
        .rsp_miss(rsp_miss), .rsp_drop(rsp_drop)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic stage_write(input int idx, input bit v, input bit p,
                               input int len, input logic [15:0] base, input int port);
        cfg_we    = 1'b1;
        cfg_idx   = IDX_W'(idx);
        cfg_valid = v;
        cfg_prot  = p;
        cfg_len   = LEN_W'(len);
        cfg_base  = base;
        cfg_port  = PORT_W'(port);
    endtask

    task automatic write_entry(input int idx, input bit v, input bit p,
                               input int len, input logic [15:0] base, input int port);
        stage_write(idx, v, p, len, base, port);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present a lookup at a falling edge, sample the answer one clock later.
    task automatic lookup(input string req, input logic [15:0] addr, input bit outside,
                          input int exp_port, input bit exp_miss, input bit exp_drop);
        lk_valid   = 1'b1;
        lk_addr    = addr;
        lk_outside = outside;
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
        lk_valid = 1'b0;
        check("R7", "rsp_valid", 32'(rsp_valid), 32'd1);
        check("R7", "rsp_addr", 32'(rsp_addr), 32'(addr));
        check(req, "rsp_port", 32'(rsp_port), 32'(exp_port));
        check(req, "rsp_miss", 32'(rsp_miss), 32'(exp_miss));
        check(req, "rsp_drop", 32'(rsp_drop), 32'(exp_drop));
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        lookup("R1", 16'h8123, 1'b0, 0, 1'b1, 1'b0);
    endtask

    task automatic t_longest;
        write_entry(0, 1, 0, 1, 16'h8000, 1);   // 1xxx...
        write_entry(1, 1, 0, 3, 16'h8000, 2);   // 100x...
        lookup("R3", 16'h8123, 1'b0, 2, 1'b0, 1'b0);
        lookup("R3", 16'h9FFF, 1'b0, 2, 1'b0, 1'b0);
        lookup("R2", 16'hC000, 1'b0, 1, 1'b0, 1'b0);
        lookup("R5", 16'h4000, 1'b0, 0, 1'b1, 1'b0);
    endtask

    task automatic t_tie;
        write_entry(3, 1, 0, 2, 16'hC000, 5);
        write_entry(2, 1, 0, 2, 16'hC000, 6);
        lookup("R4", 16'hC001, 1'b0, 6, 1'b0, 1'b0);
        lookup("R4", 16'hD000, 1'b0, 6, 1'b0, 1'b0);
        lookup("R3", 16'hA000, 1'b0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_exact_and_catchall;
        write_entry(4, 1, 0, 16, 16'h1234, 3);
        lookup("R2", 16'h1234, 1'b0, 3, 1'b0, 1'b0);
        lookup("R5", 16'h1235, 1'b0, 0, 1'b1, 1'b0);
        write_entry(15, 1, 0, 0, 16'hFFFF, 2);  // length 0: matches all
        lookup("R2", 16'h1235, 1'b0, 2, 1'b0, 1'b0);
        lookup("R3", 16'h1234, 1'b0, 3, 1'b0, 1'b0);
        write_entry(14, 1, 0, 31, 16'h0F0F, 4); // length clamps to 16
        lookup("R2", 16'h0F0F, 1'b0, 4, 1'b0, 1'b0);
        lookup("R2", 16'h0F0E, 1'b0, 2, 1'b0, 1'b0);
    endtask

    task automatic t_firewall;
        write_entry(5, 1, 1, 4, 16'h2000, 4);
        write_entry(6, 1, 0, 8, 16'h2A00, 7);
        lookup("R6", 16'h2345, 1'b1, 4, 1'b0, 1'b1);
        lookup("R6", 16'h2345, 1'b0, 4, 1'b0, 1'b0);
        lookup("R6", 16'h2ABC, 1'b1, 7, 1'b0, 1'b0);
        lookup("R6", 16'h1234, 1'b1, 3, 1'b0, 1'b0);
    endtask

    task automatic t_write_timing;
        stage_write(4, 1, 0, 16, 16'h1234, 5);
        lookup("R8", 16'h1234, 1'b0, 3, 1'b0, 1'b0);  // same cycle: old
        lookup("R8", 16'h1234, 1'b0, 5, 1'b0, 1'b0);  // next cycle: new
    endtask

    task automatic t_migrate;
        write_entry(1, 0, 0, 3, 16'h8000, 2);
        lookup("R9", 16'h8123, 1'b0, 1, 1'b0, 1'b0);
        lookup("R9", 16'hC001, 1'b0, 6, 1'b0, 1'b0);
        write_entry(6, 1, 0, 8, 16'h2A00, 3);
        lookup("R9", 16'h2ABC, 1'b0, 3, 1'b0, 1'b0);
        lookup("R9", 16'h2345, 1'b1, 4, 1'b0, 1'b1);
    endtask

    task automatic t_idle;
        lk_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_prot = 1'b0;
        cfg_len = '0; cfg_base = '0; cfg_port = '0;
        lk_valid = 1'b0; lk_addr = '0; lk_outside = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_longest;
        t_tie;
        t_exact_and_catchall;
        t_firewall;
        t_write_timing;
        t_migrate;
        t_idle;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule